// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a single-port synchronous static memory. The bus never needs an idle cycle when it changes direction. Every command (address, direction, byte-lane enables) is captured on a rising clock edge. Its data beat happens exactly two clock cycles later, for reads and for writes. A host can therefore issue any mix of reads and writes on consecutive cycles, and the data bus stays fully used.

The data bus is split into an input half, an output half and an output-enable, so that an FPGA pad or a board-level tri-state buffer can merge them into one bidirectional bus. The block drives the output-enable itself from its read pipeline, gated by an asynchronous output-enable pin.

Other controls:
- Three chip selects must all be true before a new access starts. Two of them are active-low and one is active-high.
- An active-high hold input freezes the whole block.
- An advance/load input either starts a new access at a new address or steps a four-beat burst. The burst order is linear or interleaved, chosen by a pin.

Top module: `zbt_sram`

## Requirements
- R1: A read command accepted on edge k drives its word on `dq_out`, with `dq_oe` high, from just after edge k+1 until edge k+2. Edges are counted only when `hold` is low.
- R2: A write command accepted on edge k takes `dq_in` at edge k+2. Only the lanes whose `lane_wr_n` bit was 0 with the command are written; lane i is bits [8i+7:8i].
- R3: Reads and writes may follow each other on every cycle in any order. A read issued the cycle after a write to the same word returns the newly written lanes merged with the old ones.
- R4: While `hold` is 1, all other synchronous inputs are ignored and all state keeps its value, including the output drive. Operation resumes where it stopped.
- R5: With `burst_adv` = 0, an access starts only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Otherwise nothing is written and no read data is driven for that command.
- R6: A deselect does not cancel commands already accepted; their data beats still complete.
- R7: `dq_oe` is low in every cycle that is not the data cycle of a read. This includes two cycles after a write or a deselect.
- R8: `out_en_n` = 1 forces `dq_oe` low at once, without waiting for a clock edge.
- R9: With `burst_adv` = 1 and `seq_linear` = 1, step n of a burst uses address bits [1:0] = (start + n) mod 4. The upper bits stay unchanged.
- R10: With `burst_adv` = 1 and `seq_linear` = 0, step n of a burst uses address bits [1:0] = start XOR n.
- R11: An advance repeats the direction of the burst's starting command, whatever `op_read` is. An advance after a deselected load starts nothing.
- R12: After `rst` (synchronous, active high) no command is pending and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | 1 freezes the block |
| burst_adv | input | 1 | 0 loads a new address, 1 steps the burst |
| op_read | input | 1 | 1 read, 0 write (sampled on load) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| lane_wr_n | input | LANES | Byte-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Write data bus |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Output drive enable for the data bus |

## Verification
The bench holds a behavioural model: a two-entry queue of accepted commands, a burst position counter and a word array. The model advances only on edges where `hold` is low, so every result is tied to the count of accepted edges rather than to wall-clock cycles. For each accepted edge k:
- The model commits the write that entered at edge k-2, using the `dq_in` value the bench placed in the data cycle.
- The model then expects the read that entered at edge k-1 to be on the bus.
- The bench compares `dq_oe` and `dq_out` at the falling edge after that.

The asynchronous output-enable is checked a moment after the pin changes in the middle of a cycle, with no clock edge in between.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  // number of register stages between command capture and data beat
  localparam int unsigned DATA_LAG = 2;
  // burst sequence order selected by seq_linear
  typedef enum logic {SEQ_XOR = 1'b0, SEQ_ADD = 1'b1} seq_e;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              burst_adv,
  input  logic              sel_ok,
  input  logic              op_read,
  input  logic              seq_linear,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_valid,
  output logic              cmd_read,
  output logic [ADDR_W-1:0] cmd_addr
);
  import zbt_pkg::*;

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nxt;
  logic [BURST_W-1:0] low_add;
  logic [BURST_W-1:0] low_xor;
  logic               active_q;
  logic               read_q;
  seq_e               order;

  assign order   = seq_e'(seq_linear);
  assign cnt_nxt = cnt_q + 1'b1;
  assign low_add = base_q[BURST_W-1:0] + cnt_nxt;
  assign low_xor = base_q[BURST_W-1:0] ^ cnt_nxt;

  always_comb begin
    if (!burst_adv) begin
      cmd_valid = sel_ok;
      cmd_read  = op_read;
      cmd_addr  = addr;
    end else begin
      cmd_valid = active_q;
      cmd_read  = read_q;
      cmd_addr  = {base_q[ADDR_W-1:BURST_W], (order == SEQ_ADD) ? low_add : low_xor};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      read_q   <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
    end else if (!hold) begin
      if (!burst_adv) begin
        active_q <= sel_ok;
        read_q   <= op_read;
        base_q   <= addr;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  // first step after a load, linear order
  p_first_step_add_r9: assert property (@(posedge clk) disable iff (rst)
    (!hold && !burst_adv && sel_ok) ##1 (burst_adv && seq_linear) |->
      cmd_addr == {$past(addr[ADDR_W-1:BURST_W]), BURST_W'($past(addr[BURST_W-1:0]) + 1'b1)});

  // consecutive linear steps climb by one modulo the burst length
  p_step_add_r9: assert property (@(posedge clk) disable iff (rst)
    (!hold && burst_adv && active_q && seq_linear) ##1 (burst_adv && seq_linear) |->
      cmd_addr[BURST_W-1:0] == BURST_W'($past(cmd_addr[BURST_W-1:0]) + 1'b1));

  // first step after a load, interleaved order
  p_first_step_xor_r10: assert property (@(posedge clk) disable iff (rst)
    (!hold && !burst_adv && sel_ok) ##1 (burst_adv && !seq_linear) |->
      cmd_addr == ($past(addr) ^ ADDR_W'(1)));
endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              in_valid,
  input  logic              in_read,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lane_en,
  output logic              s1_valid,
  output logic              s1_read,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              s2_valid,
  output logic              s2_read,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_lane_en
);
  import zbt_pkg::*;
  localparam int STAGES = DATA_LAG;

  logic              v_q    [STAGES];
  logic              rd_q   [STAGES];
  logic [ADDR_W-1:0] a_q    [STAGES];
  logic [LANES-1:0]  be_q   [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q[s] <= 1'b0;
        end else if (!hold) begin
          v_q[s] <= in_valid;
        end
        if (!hold) begin
          rd_q[s] <= in_read;
          a_q[s]  <= in_addr;
          be_q[s] <= in_lane_en;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q[s] <= 1'b0;
        end else if (!hold) begin
          v_q[s] <= v_q[s-1];
        end
        if (!hold) begin
          rd_q[s] <= rd_q[s-1];
          a_q[s]  <= a_q[s-1];
          be_q[s] <= be_q[s-1];
        end
      end
    end
  end

  assign s1_valid   = v_q[0];
  assign s1_read    = rd_q[0];
  assign s1_addr    = a_q[0];
  assign s2_valid   = v_q[STAGES-1];
  assign s2_read    = rd_q[STAGES-1];
  assign s2_addr    = a_q[STAGES-1];
  assign s2_lane_en = be_q[STAGES-1];

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(s1_valid) && $stable(s2_valid) &&
              $stable(s1_addr) && $stable(s2_addr) && $stable(s2_read)));
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hold,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lane_en,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic fwd;
  assign fwd = wr_en && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] wbyte;
    logic [LANE_W-1:0] rbyte_q;

    assign wbyte = wr_data[g*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (!hold && wr_en && wr_lane_en[g]) begin
        mem[wr_addr] <= wbyte;
      end
      if (!hold && rd_en) begin
        rbyte_q <= (fwd && wr_lane_en[g]) ? wbyte : mem[rd_addr];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = rbyte_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_drive <= 1'b0;
    end else if (!hold) begin
      rd_drive <= rd_en;
    end
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hold,
  input  logic                    burst_adv,
  input  logic                    op_read,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    seq_linear,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic              sel_ok;
  logic              cmd_valid;
  logic              cmd_read;
  logic [ADDR_W-1:0] cmd_addr;
  logic              s1_valid, s1_read, s2_valid, s2_read;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s2_lane_en;
  logic [DATA_W-1:0] rd_data;
  logic              rd_drive;

  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  zbt_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk(clk), .rst(rst), .hold(hold), .burst_adv(burst_adv), .sel_ok(sel_ok),
    .op_read(op_read), .seq_linear(seq_linear), .addr(addr),
    .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_addr(cmd_addr)
  );

  zbt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk(clk), .rst(rst), .hold(hold),
    .in_valid(cmd_valid), .in_read(cmd_read), .in_addr(cmd_addr), .in_lane_en(~lane_wr_n),
    .s1_valid(s1_valid), .s1_read(s1_read), .s1_addr(s1_addr),
    .s2_valid(s2_valid), .s2_read(s2_read), .s2_addr(s2_addr), .s2_lane_en(s2_lane_en)
  );

  zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst(rst), .hold(hold),
    .wr_en(s2_valid && !s2_read), .wr_addr(s2_addr), .wr_lane_en(s2_lane_en), .wr_data(dq_in),
    .rd_en(s1_valid && s1_read), .rd_addr(s1_addr),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  assign dq_out = rd_data;
  assign dq_oe  = rd_drive && !out_en_n;

  // a load with any select false leaves nothing in the first stage
  p_deselect_r5: assert property (@(posedge clk) disable iff (rst)
    (!hold && !burst_adv && (sel_a_n || !sel_b || sel_c_n)) |=> !s1_valid);

  // a read in the first stage is driven in the next cycle, also across deselects
  p_read_due_r1: assert property (@(posedge clk) disable iff (rst)
    (!hold && s1_valid && s1_read) |=> rd_drive);

  // drive only ever starts from a read
  p_drive_src_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_drive) |-> $past(s1_valid && s1_read));
endmodule

// File: tb/zbt_sram_test.sv
`timescale 1ns/1ps
module zbt_sram_test;
  localparam int AW = 6, LN = 4, LW = 8, DW = LN * LW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, hold, burst_adv, op_read, sel_a_n, sel_b, sel_c_n, seq_linear, out_en_n;
  logic [LN-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .BURST_W(2)) uut (
    .clk(clk), .rst(rst), .hold(hold), .burst_adv(burst_adv), .op_read(op_read),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .seq_linear(seq_linear),
    .lane_wr_n(lane_wr_n), .addr(addr), .dq_in(dq_in), .out_en_n(out_en_n),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct {
    bit          v;
    bit          rd;
    int unsigned a;
    bit [LN-1:0] be;
    bit [DW-1:0] wd;
  } op_t;

  int    tests = 0, fails = 0;
  string cur_req = "R12";
  op_t   p1, p2;
  bit [DW-1:0] mref [DEPTH];
  bit          exp_drv = 1'b0;
  bit [DW-1:0] exp_dat = '0;
  bit          b_act = 1'b0, b_rd = 1'b0;
  int unsigned b_base = 0, b_cnt = 0;

  task automatic model_edge();
    op_t n;
    n = '{default: 0};
    if (rst) begin
      p1 = '{default: 0}; p2 = '{default: 0};
      exp_drv = 1'b0; b_act = 1'b0; b_cnt = 0;
      return;
    end
    if (hold) return;
    if (!burst_adv) begin
      n.v = !sel_a_n && sel_b && !sel_c_n;
      n.rd = op_read; n.a = addr;
      b_act = n.v; b_rd = op_read; b_base = addr; b_cnt = 0;
    end else begin
      b_cnt = (b_cnt + 1) % 4;
      n.v = b_act; n.rd = b_rd;
      n.a = (b_base & ~32'd3) | (seq_linear ? ((b_base + b_cnt) & 3) : ((b_base ^ b_cnt) & 3));
    end
    n.be = ~lane_wr_n;
    n.wd = $urandom;
    if (p2.v && !p2.rd)
      for (int l = 0; l < LN; l++)
        if (p2.be[l]) mref[p2.a][l*LW +: LW] = dq_in[l*LW +: LW];
    exp_drv = p1.v && p1.rd;
    if (exp_drv) exp_dat = mref[p1.a];
    p2 = p1;
    p1 = n;
  endtask

  task automatic check_out();
    bit oe_exp;
    oe_exp = exp_drv && !out_en_n;
    tests++;
    if (dq_oe !== oe_exp) begin
      fails++;
      $display("FAIL %s: dq_oe=%0b expected %0b at %0t", cur_req, dq_oe, oe_exp, $time);
    end
    if (oe_exp) begin
      tests++;
      if (dq_out !== exp_dat) begin
        fails++;
        $display("FAIL %s: dq_out=%h expected %h at %0t", cur_req, dq_out, exp_dat, $time);
      end
    end
    dq_in = (p2.v && !p2.rd) ? p2.wd : DW'($urandom);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_out();
  endtask

  task automatic op(input bit rd, input int unsigned a, input bit [LN-1:0] wn = '0,
                    input bit adv = 1'b0);
    op_read = rd; addr = AW'(a); lane_wr_n = wn; burst_adv = adv;
    cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      sel_b = 1'b0; burst_adv = 1'b0; op_read = 1'($urandom); addr = AW'($urandom);
      cyc();
      sel_b = 1'b1;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL R12: watchdog expired, tests=%0d expected completion", tests);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; hold = 1'b0; burst_adv = 1'b0; op_read = 1'b1; sel_a_n = 1'b0; sel_b = 1'b1;
    sel_c_n = 1'b0; seq_linear = 1'b1; out_en_n = 1'b0; lane_wr_n = '0; addr = '0; dq_in = '0;
    @(negedge clk);
    // R12: reset state, bus released
    cur_req = "R12";
    repeat (3) cyc();
    rst = 1'b0;
    idle(2);

    // R2: fill every word with full-lane writes
    cur_req = "R2";
    for (int i = 0; i < DEPTH; i++) op(1'b0, i);
    idle(2);

    // R1: reads return words two accepted edges later
    cur_req = "R1";
    for (int i = 0; i < 16; i++) op(1'b1, (i * 7) % DEPTH);
    idle(2);

    // R3: directed read right after write to the same word, then random mixes
    cur_req = "R3";
    op(1'b0, 5); op(1'b1, 5);
    op(1'b0, 9, 4'b0101); op(1'b1, 9); op(1'b1, 5);
    op(1'b0, 5, 4'b1110); op(1'b0, 5, 4'b0111); op(1'b1, 5); op(1'b1, 5);
    for (int i = 0; i < 80; i++) op(1'($urandom), $urandom % 8, LN'($urandom));
    idle(2);

    // R2: partial lane writes, then read back
    cur_req = "R2";
    for (int i = 0; i < 24; i++) op(1'b0, $urandom % DEPTH, LN'($urandom));
    for (int i = 0; i < DEPTH; i += 3) op(1'b1, i);
    idle(2);

    // R4: random hold cycles freeze everything
    cur_req = "R4";
    for (int i = 0; i < 80; i++) begin
      hold = ($urandom % 3) == 0;
      op(1'($urandom), $urandom % 16, LN'($urandom));
    end
    hold = 1'b0;
    idle(3);

    // R5: each select false in turn blocks new accesses
    cur_req = "R5";
    for (int i = 0; i < 36; i++) begin
      case (i % 3)
        0: sel_a_n = 1'b1;
        1: sel_b = 1'b0;
        default: sel_c_n = 1'b1;
      endcase
      op(1'($urandom), $urandom % 16, LN'($urandom));
      sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
      op(1'b1, $urandom % 16);
    end
    idle(2);

    // R6: pending reads and writes finish after a deselect
    cur_req = "R6";
    op(1'b1, 3); idle(3);
    op(1'b0, 4); idle(3);
    op(1'b1, 4); op(1'b0, 6, 4'b1100); idle(3);
    op(1'b1, 6); idle(2);

    // R7: bus released after writes and deselects
    cur_req = "R7";
    op(1'b1, 10); op(1'b0, 11); op(1'b0, 12); idle(1); op(1'b1, 11); idle(3);

    // R8: asynchronous output enable
    cur_req = "R8";
    op(1'b1, 12); idle(1);
    #0.5 out_en_n = 1'b1; #0.5;
    tests++;
    if (dq_oe !== 1'b0) begin fails++; $display("FAIL R8: dq_oe=%0b expected 0", dq_oe); end
    out_en_n = 1'b0; #0.5;
    tests++;
    if (dq_oe !== 1'b1) begin fails++; $display("FAIL R8: dq_oe=%0b expected 1", dq_oe); end
    out_en_n = 1'b1;
    for (int i = 0; i < 6; i++) op(1'b1, i);
    out_en_n = 1'b0;
    idle(2);

    // R9: linear bursts, read and write, with wrap past four beats
    cur_req = "R9";
    seq_linear = 1'b1;
    op(1'b1, 6'h12); for (int i = 0; i < 5; i++) op(1'b0, 0, '0, 1'b1);
    op(1'b0, 6'h23, 4'b0000); for (int i = 0; i < 3; i++) op(1'b1, 0, LN'($urandom), 1'b1);
    op(1'b1, 6'h21); for (int i = 0; i < 3; i++) op(1'b1, 0, '0, 1'b1);
    idle(2);

    // R10: interleaved bursts
    cur_req = "R10";
    seq_linear = 1'b0;
    op(1'b1, 6'h16); for (int i = 0; i < 3; i++) op(1'b0, 0, '0, 1'b1);
    op(1'b0, 6'h2b); for (int i = 0; i < 4; i++) op(1'b1, 0, LN'($urandom), 1'b1);
    op(1'b1, 6'h29); for (int i = 0; i < 3; i++) op(1'b1, 0, '0, 1'b1);
    idle(2);

    // R11: advances after a deselected load start nothing; direction kept from load
    cur_req = "R11";
    seq_linear = 1'b1;
    sel_c_n = 1'b1; op(1'b0, 6'h30); sel_c_n = 1'b0;
    for (int i = 0; i < 4; i++) op(1'($urandom), 0, '0, 1'b1);
    op(1'b0, 6'h34, 4'b0011); for (int i = 0; i < 3; i++) op(1'b1, 0, 4'b0011, 1'b1);
    idle(2);

    // R2: final readback of the whole array
    cur_req = "R2";
    for (int i = 0; i < DEPTH; i++) op(1'b1, i);
    idle(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule